// File: doc/BRIEF.md
# Sector Access Latency Busy Timer

This block produces the busy flag and the transfer-ready request of a floppy disk controller. Every accepted command loads a countdown, and busy stays high until the countdown runs out. Most commands hold busy for a short fixed time. A sector read or write holds it for a computed latency. That latency is the part of motor spin-up still to run, plus the time the disk needs to turn until the addressed sector reaches the head. The total is never less than a fixed floor.

A free-running rotation-position counter models the turning disk. One revolution takes one fifth of the clocks in a second, which is 300 rpm. The angular offset of a sector is its index times the revolution period divided by the sectors per track. The rotational wait is that offset minus the current position. One revolution is added when the difference is negative. When the countdown expires while a transfer direction is pending, the block raises the ready request for the DMA engine. A force-interrupt command cancels everything at once.

Top module: `slt_busy_timer`

## Requirements
- R1: After reset, busy and dma_ready are low and the rotation position is zero. In that state, a sector command with index 3 of 4 issued in the first cycle after reset release waits exactly 3/4 of a revolution.
- R2: A command whose opcode is neither 8 to 11 (sector access) nor 13 (force interrupt) raises busy on the next clock edge and holds it for exactly CMD_BUSY cycles (default 20).
- R3: A sector command (opcode 8, 9, 10 or 11) holds busy for the rotational wait plus spinup_left cycles. The result is never less than MIN_WAIT cycles (default 500).
- R4: The rotational wait is floor(sec_idx * REV / sec_per_trk) minus the rotation position in the strobe cycle. REV is CLKS_PER_SEC/5. When the difference is negative, REV is added.
- R5: The rotation position advances by one each clock and wraps from REV-1 to 0.
- R6: When sec_per_trk is 0, the rotational term is zero and the wait is spinup_left, with the same floor applied.
- R7: On the edge where the countdown reaches zero, dma_ready rises if xfer_dir is nonzero (1 = into memory, 2 = out of memory, 3 = both). When xfer_dir is 0 (none), dma_ready stays low.
- R8: A force-interrupt command (opcode 13) clears busy on the next edge, cancels the pending expiry so dma_ready never rises from it, and clears dma_ready.
- R9: dma_ready clears on the edge after xfer_done is high or xfer_dir is 0. A clear takes priority over a simultaneous expiry.
- R10: A command accepted while busy restarts the countdown from the new command's duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 4 | Command opcode (upper nibble of the command byte) |
| sec_idx | input | SEC_W | Position index of the target sector on its track |
| sec_per_trk | input | SEC_W | Sectors per track; 0 disables the rotational term |
| spinup_left | input | SPIN_W | Motor spin-up clocks still remaining |
| xfer_dir | input | 2 | Pending transfer direction: 0 none, 1 in, 2 out, 3 both |
| xfer_done | input | 1 | Transfer finished; withdraws dma_ready |
| busy | output | 1 | Controller busy |
| dma_ready | output | 1 | Transfer-ready request to the DMA engine |

## Verification
Faults in this block show up mostly as timing errors, not as wrong values. If the rotation counter is off by one, or wraps one step late, the next sector command's busy interval is one cycle short or long. The directed tests catch this by placing commands at chosen positions, including the wrap point. A countdown that is not reloaded or not cancelled shows up within one cycle of the strobe as busy staying high or dropping. A stuck dma_ready latch appears at the next expiry, or one cycle after a clear condition.

// File: rtl/slt_pkg.sv
package slt_pkg;

   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_IN   = 2'd1,
      DIR_OUT  = 2'd2,
      DIR_BOTH = 2'd3
   } xfer_dir_e;

   typedef enum logic [1:0] {
      CLS_FIXED  = 2'd0,
      CLS_SECTOR = 2'd1,
      CLS_ABORT  = 2'd2
   } cmd_cls_e;

   localparam logic [3:0] OP_ABORT = 4'hD;

   function automatic cmd_cls_e op_class(input logic [3:0] op);
      cmd_cls_e c;
      if (op == OP_ABORT)
         c = CLS_ABORT;
      else if (op[3:2] == 2'b10)
         c = CLS_SECTOR;
      else
         c = CLS_FIXED;
      return c;
   endfunction

endpackage

// File: rtl/slt_rot_counter.sv
module slt_rot_counter #(
   parameter int REV   = 1000,
   parameter int POS_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [POS_W-1:0] pos
);

   localparam bit IS_POW2 = ((REV & (REV - 1)) == 0);

   generate
      if (IS_POW2) begin : g_pow2
         always_ff @(posedge clk) begin
            if (!rst_n)
               pos <= '0;
            else
               pos <= pos + POS_W'(1);
         end
      end else begin : g_cmp
         always_ff @(posedge clk) begin
            if (!rst_n)
               pos <= '0;
            else if (pos == POS_W'(REV - 1))
               pos <= '0;
            else
               pos <= pos + POS_W'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/slt_wait_calc.sv
module slt_wait_calc #(
   parameter int REV      = 1000,
   parameter int MIN_WAIT = 500,
   parameter int SEC_W    = 8,
   parameter int SPIN_W   = 12,
   parameter int POS_W    = 10,
   parameter int PROD_W   = 18,
   parameter int CNT_W    = 20
) (
   input  logic [SEC_W-1:0]  sec_idx,
   input  logic [SEC_W-1:0]  sec_per_trk,
   input  logic [POS_W-1:0]  pos,
   input  logic [SPIN_W-1:0] spinup_left,
   output logic [CNT_W-1:0]  wait_clks
);

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] divisor;
   logic [PROD_W-1:0] quot;
   logic [CNT_W-1:0]  off_c;
   logic [CNT_W-1:0]  pos_c;
   logic [CNT_W-1:0]  rot_w;
   logic [CNT_W-1:0]  total;
   logic              no_geom;

   always_comb begin
      no_geom = (sec_per_trk == '0);
      prod    = PROD_W'(sec_idx) * PROD_W'(REV);
      divisor = no_geom ? PROD_W'(1) : PROD_W'(sec_per_trk);
      quot    = prod / divisor;
      off_c   = CNT_W'(quot);
      pos_c   = CNT_W'(pos);
      if (no_geom)
         rot_w = '0;
      else if (off_c >= pos_c)
         rot_w = off_c - pos_c;
      else
         rot_w = off_c + CNT_W'(REV) - pos_c;
      total = rot_w + CNT_W'(spinup_left);
   end

   generate
      if (MIN_WAIT > 0) begin : g_floor
         always_comb
            wait_clks = (total < CNT_W'(MIN_WAIT)) ? CNT_W'(MIN_WAIT) : total;
      end else begin : g_nofloor
         always_comb
            wait_clks = total;
      end
   endgenerate

endmodule

// File: rtl/slt_countdown.sv
module slt_countdown #(
   parameter int CNT_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             busy,
   output logic             expire
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load)
         cnt <= load_val;
      else if (cnt != '0)
         cnt <= cnt - CNT_W'(1);
   end

   assign busy   = (cnt != '0);
   assign expire = !load && (cnt == CNT_W'(1));

endmodule

// File: rtl/slt_dma_req.sv
module slt_dma_req
   import slt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      expire,
   input  logic      abort,
   input  logic      xfer_done,
   input  xfer_dir_e dir,
   output logic      ready
);

   logic drop;

   assign drop = abort || xfer_done || (dir == DIR_NONE);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ready <= 1'b0;
      else if (drop)
         ready <= 1'b0;
      else if (expire)
         ready <= 1'b1;
   end

endmodule

// File: rtl/slt_busy_timer.sv
module slt_busy_timer
   import slt_pkg::*;
#(
   parameter int CLKS_PER_SEC = 5000,
   parameter int MIN_WAIT     = 500,
   parameter int CMD_BUSY     = 20,
   parameter int SEC_W        = 8,
   parameter int SPIN_W       = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [3:0]        cmd_op,
   input  logic [SEC_W-1:0]  sec_idx,
   input  logic [SEC_W-1:0]  sec_per_trk,
   input  logic [SPIN_W-1:0] spinup_left,
   input  logic [1:0]        xfer_dir,
   input  logic              xfer_done,
   output logic              busy,
   output logic              dma_ready
);

   localparam int REV    = CLKS_PER_SEC / 5;
   localparam int POS_W  = (REV > 1) ? $clog2(REV) : 1;
   localparam int REV_W  = $clog2(REV + 1);
   localparam int PROD_W = SEC_W + REV_W;
   localparam int BASE_W = (SPIN_W > PROD_W) ? SPIN_W : PROD_W;
   localparam int CNT_W  = BASE_W + 2;

   generate
      if ((CLKS_PER_SEC % 5) != 0 || CLKS_PER_SEC < 10) begin : g_bad_rate
         $error("slt_busy_timer: CLKS_PER_SEC must be a multiple of 5 and at least 10");
      end
      if (SEC_W < 1 || SPIN_W < 1) begin : g_bad_width
         $error("slt_busy_timer: SEC_W and SPIN_W must be positive");
      end
      if (MIN_WAIT < 0 || CMD_BUSY < 0) begin : g_bad_time
         $error("slt_busy_timer: MIN_WAIT and CMD_BUSY must not be negative");
      end
      if (CMD_BUSY >= (1 << BASE_W) || MIN_WAIT >= (1 << BASE_W)) begin : g_bad_fit
         $error("slt_busy_timer: fixed durations exceed the counter width");
      end
   endgenerate

   cmd_cls_e         cls;
   logic [POS_W-1:0] rot_pos;
   logic [CNT_W-1:0] sector_wait;
   logic [CNT_W-1:0] load_val;
   logic             abort;
   logic             expire;

   always_comb begin
      cls   = op_class(cmd_op);
      abort = cmd_valid && (cls == CLS_ABORT);
      unique case (cls)
         CLS_SECTOR: load_val = sector_wait;
         CLS_ABORT:  load_val = '0;
         default:    load_val = CNT_W'(CMD_BUSY);
      endcase
   end

   slt_rot_counter #(
      .REV   (REV),
      .POS_W (POS_W)
   ) u_rot (
      .clk   (clk),
      .rst_n (rst_n),
      .pos   (rot_pos)
   );

   slt_wait_calc #(
      .REV      (REV),
      .MIN_WAIT (MIN_WAIT),
      .SEC_W    (SEC_W),
      .SPIN_W   (SPIN_W),
      .POS_W    (POS_W),
      .PROD_W   (PROD_W),
      .CNT_W    (CNT_W)
   ) u_calc (
      .sec_idx     (sec_idx),
      .sec_per_trk (sec_per_trk),
      .pos         (rot_pos),
      .spinup_left (spinup_left),
      .wait_clks   (sector_wait)
   );

   slt_countdown #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cmd_valid),
      .load_val (load_val),
      .busy     (busy),
      .expire   (expire)
   );

   slt_dma_req u_dma (
      .clk       (clk),
      .rst_n     (rst_n),
      .expire    (expire),
      .abort     (abort),
      .xfer_done (xfer_done),
      .dir       (xfer_dir_e'(xfer_dir)),
      .ready     (dma_ready)
   );

endmodule

// File: rtl/slt_busy_timer_chk.sv
module slt_busy_timer_chk
   import slt_pkg::*;
#(
   parameter int MIN_WAIT = 500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [3:0] cmd_op,
   input logic [1:0] xfer_dir,
   input logic       xfer_done,
   input logic       busy,
   input logic       dma_ready
);

   logic        last_sector;
   int unsigned run_len;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_sector <= 1'b0;
         run_len     <= 0;
      end else if (cmd_valid) begin
         last_sector <= (op_class(cmd_op) == CLS_SECTOR);
         run_len     <= 0;
      end else if (busy) begin
         run_len     <= run_len + 1;
      end
   end

   a_r3_sector_busy: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && op_class(cmd_op) == CLS_SECTOR |=> busy);

   a_r3_floor_kept: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) && last_sector |-> run_len >= MIN_WAIT);

   a_r8_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_op == OP_ABORT |=> !busy && !dma_ready);

   a_r7_ready_at_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dma_ready) |-> $fell(busy));

   a_r9_clear_ready: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done || xfer_dir == 2'd0 |=> !dma_ready);

   a_r10_reload_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy && cmd_valid && op_class(cmd_op) == CLS_SECTOR |=> busy);

endmodule

bind slt_busy_timer slt_busy_timer_chk #(.MIN_WAIT(MIN_WAIT)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .xfer_dir  (xfer_dir),
   .xfer_done (xfer_done),
   .busy      (busy),
   .dma_ready (dma_ready)
);

// File: tb/slt_busy_timer_bench.sv
`timescale 1ns/1ps
module slt_busy_timer_bench;

   localparam int CPS   = 5000;
   localparam int REV   = CPS / 5;
   localparam int FLOOR = 500;
   localparam int FIXED = 20;
   localparam int LIM   = 5000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [3:0]  cmd_op = 4'h0;
   logic [7:0]  sec_idx = 8'd0;
   logic [7:0]  sec_per_trk = 8'd0;
   logic [11:0] spinup_left = 12'd0;
   logic [1:0]  xfer_dir = 2'd0;
   logic        xfer_done = 1'b0;
   logic        busy;
   logic        dma_ready;

   int checks = 0;
   int errors = 0;
   int tb_rot;
   int cyc = 0;

   always #4 clk = ~clk;

   slt_busy_timer #(.CLKS_PER_SEC(CPS), .MIN_WAIT(FLOOR), .CMD_BUSY(FIXED)) u_slt_busy_timer (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .sec_idx(sec_idx), .sec_per_trk(sec_per_trk), .spinup_left(spinup_left),
      .xfer_dir(xfer_dir), .xfer_done(xfer_done), .busy(busy), .dma_ready(dma_ready)
   );

   // Rotation model from R5: zero in reset, +1 per clock, wraps at REV
   always @(posedge clk) begin
      if (!rst_n) tb_rot <= 0;
      else tb_rot <= (tb_rot == REV - 1) ? 0 : tb_rot + 1;
   end

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         errors = errors + 1;
         checks = checks + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected fewer", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      checks = checks + 1;
      if (act != exp) begin
         errors = errors + 1;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_wait(input int idx, input int spt, input int spin, input int pos);
      int w;
      int t;
      if (spt == 0) w = 0;
      else begin
         w = (idx * REV) / spt - pos;
         if (w < 0) w = w + REV;
      end
      t = w + spin;
      if (t < FLOOR) t = FLOOR;
      return t;
   endfunction

   // Drive one command; returns at the falling edge after the load edge
   task automatic issue(input logic [3:0] op, input int idx, input int spt, input int spin,
                        output int pos);
      pos         = tb_rot;
      cmd_op      = op;
      sec_idx     = 8'(idx);
      sec_per_trk = 8'(spt);
      spinup_left = 12'(spin);
      cmd_valid   = 1'b1;
      @(posedge clk);
      @(negedge clk);
      cmd_valid   = 1'b0;
   endtask

   task automatic measure(output int n);
      n = 0;
      while (busy && n < LIM) begin
         n = n + 1;
         @(negedge clk);
      end
   endtask

   task automatic wait_rot(input int target);
      while (tb_rot != target) @(negedge clk);
   endtask

   task automatic t_reset;
      int p, n;
      chk("R1 busy after reset", int'(busy), 0);
      chk("R1 dma_ready after reset", int'(dma_ready), 0);
      issue(4'h8, 3, 4, 0, p);
      measure(n);
      chk("R1 position zero at release", n, 750);
   endtask

   task automatic t_fixed;
      int p, n;
      xfer_dir = 2'd0;
      issue(4'h0, 0, 0, 0, p);
      measure(n);
      chk("R2 fixed busy length", n, FIXED);
      chk("R7 no ready without direction", int'(dma_ready), 0);
      issue(4'hF, 0, 0, 0, p);
      measure(n);
      chk("R2 fixed busy length opcode 15", n, FIXED);
   endtask

   task automatic t_sector_sum;
      int p, n;
      wait_rot(400);
      issue(4'h9, 3, 4, 300, p);
      measure(n);
      chk("R3 rotation plus spin-up", n, exp_wait(3, 4, 300, p));
      chk("R3 rotation plus spin-up value", n, 650);
   endtask

   task automatic t_floor;
      int p, n;
      wait_rot(400);
      issue(4'hA, 2, 4, 0, p);
      measure(n);
      chk("R3 floor applied", n, FLOOR);
   endtask

   task automatic t_negative;
      int p, n;
      wait_rot(100);
      issue(4'hB, 0, 8, 0, p);
      measure(n);
      chk("R4 negative difference adds a revolution", n, 900);
      wait_rot(50);
      issue(4'h8, 5, 9, 0, p);
      measure(n);
      chk("R4 integer offset", n, exp_wait(5, 9, 0, 50));
   endtask

   task automatic t_wrap;
      int p, n;
      wait_rot(REV - 1);
      issue(4'h8, 1, 2, 100, p);
      measure(n);
      chk("R5 position at last step", n, 601);
      wait_rot(0);
      issue(4'h8, 1, 2, 100, p);
      measure(n);
      chk("R5 position after wrap", n, 600);
   endtask

   task automatic t_nogeom;
      int p, n;
      issue(4'h8, 7, 0, 700, p);
      measure(n);
      chk("R6 zero sectors per track", n, 700);
      issue(4'h8, 7, 0, 0, p);
      measure(n);
      chk("R6 zero sectors per track floor", n, FLOOR);
   endtask

   task automatic t_ready;
      int p, n;
      xfer_dir = 2'd1;
      issue(4'h0, 0, 0, 0, p);
      measure(n);
      chk("R7 ready on expiry dir in", int'(dma_ready), 1);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
      chk("R9 xfer_done clears ready", int'(dma_ready), 0);
      xfer_dir = 2'd2;
      issue(4'h1, 0, 0, 0, p);
      measure(n);
      chk("R7 ready on expiry dir out", int'(dma_ready), 1);
      xfer_dir = 2'd0;
      @(negedge clk);
      chk("R9 direction none clears ready", int'(dma_ready), 0);
   endtask

   task automatic t_abort;
      int p, n, rises;
      xfer_dir = 2'd1;
      issue(4'h8, 3, 4, 0, p);
      repeat (50) @(negedge clk);
      issue(4'hD, 0, 0, 0, p);
      chk("R8 abort clears busy", int'(busy), 0);
      rises = 0;
      for (int i = 0; i < 1200; i++) begin
         if (dma_ready) rises = rises + 1;
         @(negedge clk);
      end
      chk("R8 cancelled expiry gives no ready", rises, 0);
      issue(4'h0, 0, 0, 0, p);
      measure(n);
      chk("R7 ready before abort", int'(dma_ready), 1);
      issue(4'hD, 0, 0, 0, p);
      chk("R8 abort clears ready", int'(dma_ready), 0);
      xfer_dir = 2'd0;
   endtask

   task automatic t_restart;
      int p, n;
      issue(4'h2, 0, 0, 0, p);
      repeat (10) @(negedge clk);
      chk("R10 still busy before reload", int'(busy), 1);
      issue(4'h3, 0, 0, 0, p);
      measure(n);
      chk("R10 reload restarts count", n, FIXED);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_fixed();
      t_sector_sum();
      t_floor();
      t_negative();
      t_wrap();
      t_nogeom();
      t_ready();
      t_abort();
      t_restart();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule